// File: doc/BRIEF.md
# Shared-Pin Floppy/Printer Port Routing Switch

This block decides who drives a set of shared port pins: the floppy disk controller or the parallel port. A two-bit mode field in a control byte chooses the owner of that decision. In one group of modes, a general-purpose input pin decides. In the other group, the routing comes from register-controlled fallback values supplied by the surrounding logic. When the pin decides, the mode also fixes which floppy drives appear on the shared pins. Either drive 1 alone goes there, or both drive 0 and drive 1 do. A polarity input sets which pin level means "floppy".

The pin is resynchronised into the block clock before it is used. Every transition of the synchronised level, in either direction, sets a sticky status bit. The host clears that bit by writing a 1 to it. The status bit, qualified by two separate enable inputs, produces a power-management event request and a system-management interrupt request. Routing and edge detection apply only while the pin is selected for this function. The control byte returns to zero on the standby-power reset.

Top module: `port_share_switch`

## Requirements
- R1: After reset the control byte reads 0x00, the status bit and both event requests are 0, and the routing outputs equal the fallback inputs.
- R2: With mode field (control bits[1:0]) equal to 00 or to the reserved value 11, `fdcOwnsPort`, `drive0OnPp` and `drive1OnPp` equal `fbFdcOwn`, `fbDrive0Pp` and `fbDrive1Pp` whatever the pin does.
- R3: With `pinSelected` low, the routing outputs equal the fallback inputs in every mode.
- R4: In mode 01 or 10 with the pin selected and `pinInvert` low, a low synchronised pin gives `fdcOwnsPort`=1 and a high one gives 0.
- R5: With `pinInvert` high the pin levels of R4 are swapped: a high pin gives the floppy controller the port.
- R6: Under pin control, when the floppy controller owns the port, mode 01 gives `drive0OnPp`=0 and `drive1OnPp`=1, and mode 10 gives both 1. When the parallel port owns it, both are 0.
- R7: A pin change reaches the routing outputs on the second rising clock edge after it.
- R8: Each rising and each falling pin transition sets `edgeStatus` on the third rising clock edge after it, but only while `pinSelected` is high.
- R9: `edgeStatus` stays set until a write with `statusWrEn`=1 and `statusWrData`=1. A write of 0 leaves it set. A new edge in the same cycle as a clear leaves it set.
- R10: `pmeReq` is `edgeStatus` AND `pmeEn`, and `smiReq` is `edgeStatus` AND `smiEn`.
- R11: Writes to the control byte keep bits[1:0] and read back bits[7:2] as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low standby-power reset |
| ctrlWrEn | input | 1 | Write strobe for the control byte |
| ctrlWrData | input | 8 | Control byte write data |
| ctrlRdData | output | 8 | Control byte read data |
| pinSelected | input | 1 | The general-purpose pin is assigned to this function |
| sharePin | input | 1 | Asynchronous routing pin |
| pinInvert | input | 1 | Polarity: 1 means a high pin selects the floppy controller |
| fbFdcOwn | input | 1 | Fallback floppy-owns-port value |
| fbDrive0Pp | input | 1 | Fallback drive 0 routing |
| fbDrive1Pp | input | 1 | Fallback drive 1 routing |
| statusWrEn | input | 1 | Status write strobe |
| statusWrData | input | 1 | Status write data, 1 clears |
| pmeEn | input | 1 | Power-management event enable |
| smiEn | input | 1 | System-management interrupt enable |
| fdcOwnsPort | output | 1 | Shared pins belong to the floppy controller |
| drive0OnPp | output | 1 | Drive 0 is routed to the shared pins |
| drive1OnPp | output | 1 | Drive 1 is routed to the shared pins |
| edgeStatus | output | 1 | Sticky pin-edge status |
| pmeReq | output | 1 | Power-management event request |
| smiReq | output | 1 | System-management interrupt request |

## Verification
The bench drives the reserved mode 11 with the pin toggling. A design that treats 11 as a pin mode would let the pin steer the routing there. It checks the routing one edge before and on the second edge after a pin change, which catches a missing or extra synchroniser stage. It also checks the status one edge before and on the third edge, which exposes a detector that counts only one direction. It collides a clear with a fresh edge, where a design that gives the clear priority drops an event. It toggles the pin while the pin is deselected, where a design that ignores the selection raises spurious status.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int CTRL_W = 8;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_REG      = 2'b00,
    MODE_PIN_D1   = 2'b01,
    MODE_PIN_BOTH = 2'b10,
    MODE_RSVD     = 2'b11
  } pswMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pinOwns;     // pin decides routing
    logic bothDrives;  // drive 0 also goes to shared pins
    logic edgeEnable;  // pin assigned to this function
  } pswStrobe_t;
endpackage

// File: rtl/psw_datapath.sv
module psw_datapath
  import psw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  pswStrobe_t strobes,
  input  logic       sharePin,
  input  logic       pinInvert,
  input  logic       fbFdcOwn,
  input  logic       fbDrive0Pp,
  input  logic       fbDrive1Pp,
  output logic       edgePulse,
  output logic       fdcOwnsPort,
  output logic       drive0OnPp,
  output logic       drive1OnPp
);
  localparam int ARM_MAX = SYNC_STAGES + 1;
  localparam int ARM_W   = $clog2(ARM_MAX + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   prevQ;
  logic [ARM_W-1:0]       armCnt;
  logic                   armed;
  logic                   pinLevel;
  logic                   fdcPick;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= sharePin;
    end else begin : g_syncN
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], sharePin};
    end
  endgenerate

  assign pinLevel = syncQ[SYNC_STAGES-1];
  assign armed    = (armCnt == ARM_W'(ARM_MAX));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ  <= 1'b0;
      armCnt <= '0;
    end else begin
      prevQ <= pinLevel;
      if (!armed) armCnt <= armCnt + ARM_W'(1);
    end
  end

  assign edgePulse = armed && strobes.edgeEnable && (pinLevel != prevQ);
  assign fdcPick   = pinInvert ? pinLevel : ~pinLevel;

  always_comb begin
    if (strobes.pinOwns) begin
      fdcOwnsPort = fdcPick;
      drive1OnPp  = fdcPick;
      drive0OnPp  = fdcPick && strobes.bothDrives;
    end else begin
      fdcOwnsPort = fbFdcOwn;
      drive1OnPp  = fbDrive1Pp;
      drive0OnPp  = fbDrive0Pp;
    end
  end

  // R6: under pin control drive 0 never moves without drive 1
  p_drive_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.pinOwns && drive0OnPp) |-> drive1OnPp);
  // R8: no edge reported while the pin is deselected
  p_edge_gated_r8: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |-> strobes.edgeEnable);
endmodule

// File: rtl/psw_ctrl.sv
module psw_ctrl
  import psw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  input  logic              pinSelected,
  input  logic              statusWrEn,
  input  logic              statusWrData,
  input  logic              edgePulse,
  output logic [CTRL_W-1:0] ctrlRdData,
  output logic              statusQ,
  output pswStrobe_t        strobes
);
  pswMode_e modeQ;
  logic     clearReq;
  logic     unusedRsvd;

  assign unusedRsvd = ^ctrlWrData[CTRL_W-1:MODE_W];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN)         modeQ <= MODE_REG;
    else if (ctrlWrEn) modeQ <= pswMode_e'(ctrlWrData[MODE_W-1:0]);

  assign ctrlRdData = {{(CTRL_W-MODE_W){1'b0}}, modeQ};
  assign clearReq   = statusWrEn && statusWrData;

  // set wins over clear
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)          statusQ <= 1'b0;
    else if (edgePulse) statusQ <= 1'b1;
    else if (clearReq)  statusQ <= 1'b0;

  always_comb begin
    strobes.edgeEnable = pinSelected;
    strobes.pinOwns    = pinSelected &&
                         (modeQ == MODE_PIN_D1 || modeQ == MODE_PIN_BOTH);
    strobes.bothDrives = (modeQ == MODE_PIN_BOTH);
  end

  p_edge_sets_r8: assert property (@(posedge clk) disable iff (!rstN)
    edgePulse |=> statusQ);
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ && !clearReq) |=> statusQ);
  p_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    (clearReq && !edgePulse) |=> !statusQ);
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlWrEn |=> $stable(modeQ));
endmodule

// File: rtl/port_share_switch.sv
module port_share_switch
  import psw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWrEn,
  input  logic [CTRL_W-1:0] ctrlWrData,
  output logic [CTRL_W-1:0] ctrlRdData,
  input  logic              pinSelected,
  input  logic              sharePin,
  input  logic              pinInvert,
  input  logic              fbFdcOwn,
  input  logic              fbDrive0Pp,
  input  logic              fbDrive1Pp,
  input  logic              statusWrEn,
  input  logic              statusWrData,
  input  logic              pmeEn,
  input  logic              smiEn,
  output logic              fdcOwnsPort,
  output logic              drive0OnPp,
  output logic              drive1OnPp,
  output logic              edgeStatus,
  output logic              pmeReq,
  output logic              smiReq
);
  pswStrobe_t strobes;
  logic       edgePulse;

  psw_ctrl u_ctrl (
    .clk, .rstN, .ctrlWrEn, .ctrlWrData, .pinSelected,
    .statusWrEn, .statusWrData, .edgePulse,
    .ctrlRdData, .statusQ(edgeStatus), .strobes
  );

  psw_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk, .rstN, .strobes, .sharePin, .pinInvert,
    .fbFdcOwn, .fbDrive0Pp, .fbDrive1Pp,
    .edgePulse, .fdcOwnsPort, .drive0OnPp, .drive1OnPp
  );

  assign pmeReq = edgeStatus & pmeEn;
  assign smiReq = edgeStatus & smiEn;

  p_pme_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    pmeReq |-> (pmeEn && edgeStatus));
  p_smi_gate_r10: assert property (@(posedge clk) disable iff (!rstN)
    smiReq |-> (smiEn && edgeStatus));
endmodule

// File: tb/port_share_switch_tb.sv
module port_share_switch_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWrEn = 1'b0;
  logic [7:0] ctrlWrData = '0;
  logic [7:0] ctrlRdData;
  logic pinSelected = 1'b0, sharePin = 1'b0, pinInvert = 1'b0;
  logic fbFdcOwn = 1'b1, fbDrive0Pp = 1'b0, fbDrive1Pp = 1'b1;
  logic statusWrEn = 1'b0, statusWrData = 1'b0, pmeEn = 1'b0, smiEn = 1'b0;
  logic fdcOwnsPort, drive0OnPp, drive1OnPp, edgeStatus, pmeReq, smiReq;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  port_share_switch u_dut (.*);

  // [10:9] mode, [8] pinSelected, [7] pinInvert, [6] pin,
  // [5:3] fallback {fdc,d0,d1}, [2:0] expected {fdc,d0,d1}
  localparam int NV = 12;
  localparam logic [10:0] VEC [NV] = '{
    {2'b00, 1'b1, 1'b0, 1'b0, 3'b101, 3'b101},
    {2'b00, 1'b1, 1'b0, 1'b1, 3'b010, 3'b010},
    {2'b11, 1'b1, 1'b0, 1'b0, 3'b011, 3'b011},
    {2'b01, 1'b0, 1'b0, 1'b0, 3'b110, 3'b110},
    {2'b01, 1'b1, 1'b0, 1'b0, 3'b000, 3'b101},
    {2'b01, 1'b1, 1'b0, 1'b1, 3'b111, 3'b000},
    {2'b10, 1'b1, 1'b0, 1'b0, 3'b000, 3'b111},
    {2'b10, 1'b1, 1'b0, 1'b1, 3'b111, 3'b000},
    {2'b01, 1'b1, 1'b1, 1'b1, 3'b000, 3'b101},
    {2'b01, 1'b1, 1'b1, 1'b0, 3'b111, 3'b000},
    {2'b10, 1'b1, 1'b1, 1'b1, 3'b000, 3'b111},
    {2'b10, 1'b0, 1'b0, 1'b0, 3'b001, 3'b001}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic writeCtrl(input logic [7:0] d);
    ctrlWrData = d; ctrlWrEn = 1'b1; tick(1); ctrlWrEn = 1'b0;
  endtask

  task automatic clearStatus();
    statusWrData = 1'b1; statusWrEn = 1'b1; tick(1); statusWrEn = 1'b0;
  endtask

  initial begin
    #1ms;
    nFails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 ctrl", ctrlRdData, 8'h00);
    chk("R1 status/events", {edgeStatus, pmeReq, smiReq}, 8'h0);
    chk("R1 routing", {fdcOwnsPort, drive0OnPp, drive1OnPp}, 8'b101);

    // R11 reserved bits
    writeCtrl(8'hFF);
    chk("R11 rsvd", ctrlRdData, 8'h03);
    writeCtrl(8'hA6);
    chk("R11 mode", ctrlRdData, 8'h02);

    // routing table: R2 R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      writeCtrl({6'h0, VEC[v][10:9]});
      pinSelected = VEC[v][8]; pinInvert = VEC[v][7]; sharePin = VEC[v][6];
      {fbFdcOwn, fbDrive0Pp, fbDrive1Pp} = VEC[v][5:3];
      tick(4);
      if (VEC[v][10:9] == 2'b00 || VEC[v][10:9] == 2'b11)
        chk("R2 routing", {fdcOwnsPort, drive0OnPp, drive1OnPp}, VEC[v][2:0]);
      else if (!VEC[v][8])
        chk("R3 routing", {fdcOwnsPort, drive0OnPp, drive1OnPp}, VEC[v][2:0]);
      else if (VEC[v][7])
        chk("R5 routing", {fdcOwnsPort, drive0OnPp, drive1OnPp}, VEC[v][2:0]);
      else
        chk("R4 R6 routing", {fdcOwnsPort, drive0OnPp, drive1OnPp}, VEC[v][2:0]);
    end

    // R2: reserved mode ignores a toggling pin
    writeCtrl(8'h03); pinSelected = 1'b1; pinInvert = 1'b0;
    {fbFdcOwn, fbDrive0Pp, fbDrive1Pp} = 3'b010;
    sharePin = 1'b0; tick(4);
    chk("R2 rsvd low", {fdcOwnsPort, drive0OnPp, drive1OnPp}, 8'b010);
    sharePin = 1'b1; tick(4);
    chk("R2 rsvd high", {fdcOwnsPort, drive0OnPp, drive1OnPp}, 8'b010);

    // R7 / R8 latency, falling edge
    writeCtrl(8'h01); sharePin = 1'b1; tick(4); clearStatus();
    sharePin = 1'b0;
    tick(1);
    chk("R7 after 1 edge", fdcOwnsPort, 1'b0);
    tick(1);
    chk("R7 after 2 edges", fdcOwnsPort, 1'b1);
    chk("R8 after 2 edges", edgeStatus, 1'b0);
    tick(1);
    chk("R8 fall sets", edgeStatus, 1'b1);
    // R8 rising edge
    clearStatus();
    chk("R9 cleared", edgeStatus, 1'b0);
    sharePin = 1'b1; tick(3);
    chk("R8 rise sets", edgeStatus, 1'b1);

    // R9 write 0 no effect
    statusWrData = 1'b0; statusWrEn = 1'b1; tick(1); statusWrEn = 1'b0;
    chk("R9 write0", edgeStatus, 1'b1);

    // R10 gating
    pmeEn = 1'b1; smiEn = 1'b0; tick(1);
    chk("R10 pme only", {pmeReq, smiReq}, 8'b10);
    pmeEn = 1'b0; smiEn = 1'b1; tick(1);
    chk("R10 smi only", {pmeReq, smiReq}, 8'b01);
    clearStatus();
    chk("R10 no status", {pmeReq, smiReq}, 8'b00);

    // R9 set wins over clear in same cycle
    sharePin = 1'b0;
    tick(2);
    statusWrData = 1'b1; statusWrEn = 1'b1; tick(1); statusWrEn = 1'b0;
    tick(1);
    chk("R9 set beats clear", edgeStatus, 1'b1);
    clearStatus();

    // R8 deselected pin raises nothing
    pinSelected = 1'b0;
    sharePin = 1'b1; tick(4);
    sharePin = 1'b0; tick(4);
    chk("R8 deselected", edgeStatus, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule